// File: doc/BRIEF.md
# Two-Stage I2C Clock-Enable Divider

This block turns a fast reference clock into the two timing signals an I2C master needs. One is a one-cycle sampling strobe that the protocol logic uses to sample and drive the bus. The other is the outgoing SCL waveform.

A configuration word is written over a simple write port and can be read back. Two divider fields set the strobe rate. A 2-bit prescale value A divides the reference clock by A+1. A 6-bit value B then divides that result by B+1. The strobe therefore fires once every (A+1)*(B+1) reference cycles. SCL toggles after every 11 strobes, so one full SCL period lasts 22*(A+1)*(B+1) reference cycles.

The same configuration word holds two other bits. One is a HOLD flag that is passed to the protocol logic. The other is a command bit that clears the FIFOs: it raises a one-cycle pulse and is never stored. A change to A or B takes effect only at the end of the strobe period in progress, so the strobe is never cut short. The default field values give about 400 kHz from a 125 MHz reference.

Top module: `i2c_scl_divider`

## Requirements
- R1: Bits [15:14] of the configuration word hold A and bits [13:8] hold B. Bit 4 is HOLD. Every bit except bit 6 reads back as last written. After reset the word reads 16'h0D00, which is A=0 and B=13.
- R2: The sampling strobe rises once every (A+1)*(B+1) reference cycles. When that product exceeds 1, each strobe lasts exactly one cycle.
- R3: While the bus is active, SCL is low for 11*(A+1)*(B+1) cycles and high for the same time, giving a period of 22*(A+1)*(B+1) cycles. SCL changes only on a strobe cycle.
- R4: When the bus-active input is low, SCL is high from the next clock edge onward.
- R5: New A and B values take effect only at the next strobe. The strobe period that was running when the write happened keeps the old length, and the next period uses the new length.
- R6: Writing a 1 to bit 6 raises fifoClr for exactly the cycle after the write. Bit 6 reads back as 0. Such a write, when it carries the same A and B, leaves the strobe period unchanged.
- R7: holdFlag follows the stored bit 4 of the configuration word.
- R8: After reset, SCL is high, fifoClr is low, and both divider counters start from zero. The first strobe period therefore uses the reset field values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWdata | input | 16 | Configuration write data |
| busActive | input | 1 | High while the master drives the bus |
| cfgRdata | output | 16 | Configuration word read-back |
| sampleTick | output | 1 | One-cycle sampling strobe |
| scl | output | 1 | Outgoing SCL level |
| fifoClr | output | 1 | One-cycle FIFO-clear command pulse |
| holdFlag | output | 1 | Stored HOLD bit |

## Verification
The read-back word, holdFlag and fifoClr are registered once, so they are sampled on the falling edge that follows the write edge. A new divider setting applies only after the first strobe that comes after the write. For that reason the bench waits for one strobe before it measures any period. It then counts falling edges from one strobe to the next, and from one SCL edge to the next, and compares each count with (A+1)*(B+1) or with 11 or 22 times that value. For the reload case, the write is placed three cycles into a strobe period, and the bench expects the old period first and the new period second.

// File: rtl/i2c_div_pkg.sv
package i2c_div_pkg;
  localparam int CFG_W        = 16;
  localparam int DIV_A_W      = 2;
  localparam int DIV_B_W      = 6;
  localparam int DIV_A_LSB    = 14;
  localparam int DIV_B_LSB    = 8;
  localparam int FIFO_CLR_BIT = 6;
  localparam int HOLD_BIT     = 4;

  // Strobes and limits passed from control to datapath
  typedef struct packed {
    logic               sclRun;
    logic [DIV_A_W-1:0] limA;
    logic [DIV_B_W-1:0] limB;
  } divStrobeT;
endpackage

// File: rtl/i2c_div_ctrl.sv
module i2c_div_ctrl
  import i2c_div_pkg::*;
#(
  parameter logic [DIV_A_W-1:0] RST_A = '0,
  parameter logic [DIV_B_W-1:0] RST_B = 6'd13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWdata,
  input  logic             busActive,
  input  logic             tick,
  output logic [CFG_W-1:0] cfgRdata,
  output logic             fifoClr,
  output logic             holdFlag,
  output divStrobeT        strb
);
  localparam logic [CFG_W-1:0] RST_CFG =
    (CFG_W'(RST_A) << DIV_A_LSB) | (CFG_W'(RST_B) << DIV_B_LSB);
  localparam logic [CFG_W-1:0] STORE_MASK = ~(CFG_W'(1) << FIFO_CLR_BIT);

  logic [CFG_W-1:0]   cfgReg;
  logic [DIV_A_W-1:0] cfgA;
  logic [DIV_B_W-1:0] cfgB;
  logic [DIV_A_W-1:0] limA;
  logic [DIV_B_W-1:0] limB;

  assign cfgA = cfgReg[DIV_A_LSB +: DIV_A_W];
  assign cfgB = cfgReg[DIV_B_LSB +: DIV_B_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg  <= RST_CFG;
      fifoClr <= 1'b0;
    end else begin
      fifoClr <= cfgWe && cfgWdata[FIFO_CLR_BIT];
      if (cfgWe) cfgReg <= cfgWdata & STORE_MASK;
    end
  end

  // Active limits reload only on a strobe so no period is truncated
  always_ff @(posedge clk) begin
    if (!rstN) begin
      limA <= RST_A;
      limB <= RST_B;
    end else if (tick) begin
      limA <= cfgA;
      limB <= cfgB;
    end
  end

  assign cfgRdata  = cfgReg;
  assign holdFlag  = cfgReg[HOLD_BIT];
  assign strb.sclRun = busActive;
  assign strb.limA   = limA;
  assign strb.limB   = limB;

  // R5
  limits_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> ($stable(strb.limA) && $stable(strb.limB)));
  // R6
  fifo_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgWdata[FIFO_CLR_BIT]) |=> fifoClr);
  // R6
  fifo_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgWe && cfgWdata[FIFO_CLR_BIT]) |=> !fifoClr);
  // R2
  single_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && (cfgA != '0 || cfgB != '0)) |=> !tick);
endmodule

// File: rtl/i2c_div_datapath.sv
module i2c_div_datapath
  import i2c_div_pkg::*;
#(
  parameter int SCL_HALF = 11
) (
  input  logic      clk,
  input  logic      rstN,
  input  divStrobeT strb,
  output logic      tick,
  output logic      scl
);
  localparam int HALF_W = $clog2(SCL_HALF);
  localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(SCL_HALF - 1);

  logic [DIV_A_W-1:0] preCnt;
  logic [DIV_B_W-1:0] divCnt;
  logic [HALF_W-1:0]  sclCnt;
  logic               preTc;
  logic               divTc;

  assign preTc = (preCnt == strb.limA);
  assign divTc = (divCnt == strb.limB);
  assign tick  = preTc && divTc;

  // Prescaler then main divider
  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      divCnt <= '0;
    end else if (preTc) begin
      preCnt <= '0;
      divCnt <= divTc ? '0 : divCnt + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  // SCL toggles every SCL_HALF strobes while the bus is active
  always_ff @(posedge clk) begin
    if (!rstN || !strb.sclRun) begin
      sclCnt <= '0;
      scl    <= 1'b1;
    end else if (tick) begin
      if (sclCnt == HALF_LAST) begin
        sclCnt <= '0;
        scl    <= ~scl;
      end else begin
        sclCnt <= sclCnt + 1'b1;
      end
    end
  end

  // R4
  scl_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.sclRun |=> scl);
  // R3
  scl_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sclRun && !tick) |=> $stable(scl));
  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (preCnt <= strb.limA) && (divCnt <= strb.limB));
endmodule

// File: rtl/i2c_scl_divider.sv
module i2c_scl_divider
  import i2c_div_pkg::*;
#(
  parameter logic [DIV_A_W-1:0] RST_A    = '0,
  parameter logic [DIV_B_W-1:0] RST_B    = 6'd13,
  parameter int                 SCL_HALF = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWdata,
  input  logic             busActive,
  output logic [CFG_W-1:0] cfgRdata,
  output logic             sampleTick,
  output logic             scl,
  output logic             fifoClr,
  output logic             holdFlag
);
  divStrobeT strb;
  logic      tick;

  i2c_div_ctrl #(.RST_A(RST_A), .RST_B(RST_B)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .busActive(busActive), .tick(tick), .cfgRdata(cfgRdata),
    .fifoClr(fifoClr), .holdFlag(holdFlag), .strb(strb)
  );

  i2c_div_datapath #(.SCL_HALF(SCL_HALF)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .tick(tick), .scl(scl)
  );

  assign sampleTick = tick;
endmodule

// File: tb/i2c_scl_divider_test.sv
module i2c_scl_divider_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [15:0] cfgWdata = '0;
  logic        busActive = 1'b0;
  logic [15:0] cfgRdata;
  logic        sampleTick, scl, fifoClr, holdFlag;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_scl_divider uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .busActive(busActive), .cfgRdata(cfgRdata), .sampleTick(sampleTick),
    .scl(scl), .fifoClr(fifoClr), .holdFlag(holdFlag)
  );

  // {A, B} pairs
  localparam logic [7:0] VEC [5] = '{
    {2'd0, 6'd0}, {2'd1, 6'd2}, {2'd3, 6'd5}, {2'd2, 6'd0}, {2'd0, 6'd9}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cfgWord(input int a, input int b, input bit hold);
    return 16'((a << 14) | (b << 8) | (int'(hold) << 4));
  endfunction

  task automatic writeCfg(input logic [15:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic waitTick();
    do @(negedge clk); while (!sampleTick);
  endtask

  // Called while sampleTick is high; counts cycles to the next strobe
  task automatic tickGap(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!sampleTick);
  endtask

  task automatic waitSclEdge(input bit lvl, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (scl != lvl);
  endtask

  initial begin
    int gap, lowT, highT, p;
    repeat (3) @(negedge clk);
    // R8 R1 reset state
    check("R1 reset word", cfgRdata, 16'h0D00);
    check("R8 reset scl", scl, 1);
    check("R8 reset fifoClr", fifoClr, 0);
    rstN = 1'b1;
    waitTick();
    tickGap(gap);
    check("R8 reset period", gap, 14);

    for (int i = 0; i < 5; i++) begin
      int a = int'(VEC[i][7:6]);
      int b = int'(VEC[i][5:0]);
      p = (a + 1) * (b + 1);
      busActive = 1'b0;
      writeCfg(cfgWord(a, b, i[0]));
      check("R1 readback", cfgRdata, cfgWord(a, b, i[0]));
      check("R7 hold", holdFlag, i[0]);
      waitTick();
      tickGap(gap);
      check("R2 tick period", gap, p);
      if (p > 1) begin
        @(negedge clk);
        check("R2 tick width", sampleTick, 0);
      end
      busActive = 1'b1;
      waitSclEdge(1'b0, gap);
      waitSclEdge(1'b1, lowT);
      waitSclEdge(1'b0, highT);
      check("R3 scl low", lowT, 11 * p);
      check("R3 scl high", highT, 11 * p);
      busActive = 1'b0;
      @(negedge clk);
      check("R4 idle scl", scl, 1);
      repeat (5) @(negedge clk);
      check("R4 idle scl held", scl, 1);
    end

    // R5 reload at strobe: old period 8, then new period 5
    writeCfg(cfgWord(1, 3, 0));
    waitTick();
    waitTick();
    repeat (3) @(negedge clk);
    cfgWe = 1'b1; cfgWdata = cfgWord(0, 4, 0);
    @(negedge clk);
    cfgWe = 1'b0;
    gap = 4;
    while (!sampleTick) begin @(negedge clk); gap++; end
    check("R5 old period kept", gap, 8);
    tickGap(gap);
    check("R5 new period", gap, 5);

    // R6 FIFO clear pulse, self clearing, dividers intact
    writeCfg(cfgWord(0, 4, 1) | 16'h0040);
    check("R6 fifoClr pulse", fifoClr, 1);
    check("R6 bit6 reads zero", cfgRdata, cfgWord(0, 4, 1));
    check("R7 hold set", holdFlag, 1);
    @(negedge clk);
    check("R6 fifoClr one cycle", fifoClr, 0);
    waitTick();
    tickGap(gap);
    check("R6 period unchanged", gap, 5);
    writeCfg(cfgWord(0, 4, 0));
    check("R6 no pulse", fifoClr, 0);
    check("R7 hold cleared", holdFlag, 0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule